// File: doc/BRIEF.md
# Fetch-Stage Branch Target Predictor

This block sits beside the program counter in the fetch stage of a pipelined core. Each cycle it looks up the address being fetched in a small direct-mapped table and proposes the next fetch address. A valid entry with a matching tag yields the stored target and raises a predicted-taken flag. Otherwise the proposal is the sequential address, the fetch address plus one instruction word.

A later stage reports each resolved branch. It gives the branch address, the real target and whether the branch was taken. A taken branch is written into the slot picked by its low address bits, replacing whatever was there. A not-taken branch removes its own entry, so the next prediction for it falls through. Prediction therefore follows only the most recent outcome of each branch. When a misprediction is found, the resolving stage drives a redirect with the correct address. That redirect takes priority over the table for the same cycle.

Top module: `btb_predictor`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses until a taken update has been written.
- R2: On a miss with no redirect, `next_pc` equals `fetch_pc + 2**OFFS` (modulo 2**AW) and `pred_taken` is 0.
- R3: A taken update (`upd_valid`=1, `upd_taken`=1) writes its entry at the clock edge. From the next cycle, fetching that branch address gives `pred_taken`=1 and `next_pc` equal to the recorded target.
- R4: The table index is `fetch_pc[OFFS +: log2(ENTRIES)]` and the tag is the remaining upper bits. A fetch address with the same index but a different tag misses.
- R5: A taken update whose index is already occupied by a different branch overwrites it. The old branch then misses and the new one hits.
- R6: A not-taken update invalidates the entry at its index only when the stored tag matches. From the next cycle that branch misses. A not-taken update with a different tag leaves the stored entry in place.
- R7: When `redirect_valid` is 1, `next_pc` equals `redirect_pc` and `pred_taken` is 0 in that same cycle, whatever the table holds.
- R8: A lookup and an update to the same index in the same cycle see the contents from before the update.
- R9: A loop-closing branch that is taken N-1 times and then not taken is mispredicted exactly twice per run of the loop: on its first and its last execution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset, clears all valid bits |
| fetch_pc | input | AW | Address of the instruction being fetched |
| next_pc | output | AW | Proposed next fetch address |
| pred_taken | output | 1 | High when `next_pc` comes from a table hit |
| upd_valid | input | 1 | A resolved branch is reported this cycle |
| upd_pc | input | AW | Address of the resolved branch |
| upd_target | input | AW | Actual target of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |
| redirect_valid | input | 1 | Misprediction correction present |
| redirect_pc | input | AW | Correct fetch address that overrides the prediction |

## Verification
The bench builds the block with AW=12, ENTRIES=8 and OFFS=2. With these values every table slot is swept by index. The 7-bit tag makes aliasing addresses easy to form, and the top address 12'hFFC shows the sequential increment wrapping to zero. A bench-side shadow table, written from the requirements, supplies the expected value for every lookup. This covers same-cycle update collisions, redirect priority and a two-run loop whose mispredictions are counted.

// File: rtl/btb_predictor.sv
module btb_predictor #(
  parameter int AW      = 32,
  parameter int ENTRIES = 16,
  parameter int OFFS    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] fetch_pc,
  output logic [AW-1:0] next_pc,
  output logic          pred_taken,
  input  logic          upd_valid,
  input  logic [AW-1:0] upd_pc,
  input  logic [AW-1:0] upd_target,
  input  logic          upd_taken,
  input  logic          redirect_valid,
  input  logic [AW-1:0] redirect_pc
);
  localparam int IW = $clog2(ENTRIES);
  localparam int TW = AW - IW - OFFS;
  localparam logic [AW-1:0] STEP = AW'(1) << OFFS;

  logic [ENTRIES-1:0] vld;
  logic [TW-1:0]      tags [ENTRIES];
  logic [AW-1:0]      tgts [ENTRIES];

  wire [IW-1:0] l_idx = fetch_pc[OFFS +: IW];
  wire [TW-1:0] l_tag = fetch_pc[AW-1 -: TW];
  wire [IW-1:0] u_idx = upd_pc[OFFS +: IW];
  wire [TW-1:0] u_tag = upd_pc[AW-1 -: TW];

  wire hit   = vld[l_idx] && (tags[l_idx] == l_tag);
  wire u_own = vld[u_idx] && (tags[u_idx] == u_tag);

  assign pred_taken = hit && !redirect_valid;
  assign next_pc    = redirect_valid ? redirect_pc :
                      hit            ? tgts[l_idx] : fetch_pc + STEP;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
    end else if (upd_valid) begin
      if (upd_taken)  vld[u_idx] <= 1'b1;
      else if (u_own) vld[u_idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (upd_valid && upd_taken) begin
      tags[u_idx] <= u_tag;
      tgts[u_idx] <= upd_target;
    end
  end
endmodule

module btb_predictor_chk #(
  parameter int AW   = 32,
  parameter int OFFS = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] fetch_pc,
  input logic [AW-1:0] next_pc,
  input logic          pred_taken,
  input logic          upd_valid,
  input logic [AW-1:0] upd_pc,
  input logic [AW-1:0] upd_target,
  input logic          upd_taken,
  input logic          redirect_valid,
  input logic [AW-1:0] redirect_pc
);
  localparam logic [AW-1:0] STEP = AW'(1) << OFFS;

  a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !pred_taken);

  a_r2_sequential_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (!pred_taken && !redirect_valid) |-> next_pc == fetch_pc + STEP);

  a_r3_taken_update_hits: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_taken) |=>
      (!(fetch_pc == $past(upd_pc) && !redirect_valid) ||
       (pred_taken && next_pc == $past(upd_target))));

  a_r6_not_taken_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_taken) |=> !(fetch_pc == $past(upd_pc) && pred_taken));

  a_r7_redirect_wins: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> (next_pc == redirect_pc && !pred_taken));
endmodule

bind btb_predictor btb_predictor_chk #(.AW(AW), .OFFS(OFFS)) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .next_pc(next_pc),
  .pred_taken(pred_taken), .upd_valid(upd_valid), .upd_pc(upd_pc),
  .upd_target(upd_target), .upd_taken(upd_taken),
  .redirect_valid(redirect_valid), .redirect_pc(redirect_pc));

// File: tb/btb_predictor_tb.sv
`timescale 1ns/1ps
module btb_predictor_tb;
  localparam int AW = 12, ENT = 8, OFFS = 2, IW = 3, TW = AW - IW - OFFS;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] fetch_pc = '0, upd_pc = '0, upd_target = '0, redirect_pc = '0;
  logic upd_valid = 0, upd_taken = 0, redirect_valid = 0;
  wire  [AW-1:0] next_pc;
  wire  pred_taken;

  btb_predictor #(.AW(AW), .ENTRIES(ENT), .OFFS(OFFS)) u_dut (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .next_pc(next_pc),
    .pred_taken(pred_taken), .upd_valid(upd_valid), .upd_pc(upd_pc),
    .upd_target(upd_target), .upd_taken(upd_taken),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc));

  always #5 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  logic          m_v [ENT];
  logic [TW-1:0] m_t [ENT];
  logic [AW-1:0] m_g [ENT];
  logic          o_pt;
  logic [AW-1:0] o_np;

  function automatic logic [AW-1:0] mk(input int tag, input int idx);
    return AW'((tag << (IW + OFFS)) | (idx << OFFS));
  endfunction

  task automatic step(input logic [AW-1:0] fpc, input logic uv, input logic [AW-1:0] upc,
                      input logic [AW-1:0] utg, input logic utk, input logic rv,
                      input logic [AW-1:0] rpc, input string req);
    int li, ui;
    logic hit, e_pt;
    logic [AW-1:0] e_np;
    @(negedge clk);
    fetch_pc = fpc; upd_valid = uv; upd_pc = upc; upd_target = utg;
    upd_taken = utk; redirect_valid = rv; redirect_pc = rpc;
    #1;
    li  = int'(fpc[OFFS +: IW]);
    hit = m_v[li] && m_t[li] == fpc[AW-1 -: TW];
    e_pt = hit && !rv;
    e_np = rv ? rpc : hit ? m_g[li] : AW'(fpc + 4);
    o_pt = pred_taken; o_np = next_pc;
    n_cmp++;
    if (pred_taken !== e_pt || next_pc !== e_np) begin
      n_bad++;
      $display("FAIL %s pc=%h: got next=%h taken=%b, expected next=%h taken=%b",
               req, fpc, next_pc, pred_taken, e_np, e_pt);
    end
    @(posedge clk);
    if (uv) begin
      ui = int'(upc[OFFS +: IW]);
      if (utk) begin m_v[ui] = 1; m_t[ui] = upc[AW-1 -: TW]; m_g[ui] = utg; end
      else if (m_v[ui] && m_t[ui] == upc[AW-1 -: TW]) m_v[ui] = 0;
    end
  endtask

  task automatic look(input logic [AW-1:0] fpc, input string req);
    step(fpc, 0, '0, '0, 0, 0, '0, req);
  endtask

  task automatic upd(input logic [AW-1:0] upc, input logic [AW-1:0] tg,
                     input logic tk, input string req);
    step(12'h000, 1, upc, tg, tk, 0, '0, req);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 20000) begin @(posedge clk); cyc++; end
    n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int miss;
    for (int i = 0; i < ENT; i++) begin m_v[i] = 0; m_t[i] = '0; m_g[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: empty table, every slot misses
    for (int i = 0; i < ENT; i++) look(mk(i * 9 + 3, i), "R1");
    // R2: sequential next address, including wrap
    look(12'h7F0, "R2"); look(12'hFFC, "R2"); look(12'h004, "R2");
    // R3: fill every slot with a taken branch, then hit each one
    for (int i = 0; i < ENT; i++) upd(mk(i * 5 + 1, i), AW'(12'h800 + i * 16), 1, "R3");
    for (int i = 0; i < ENT; i++) look(mk(i * 5 + 1, i), "R3");
    // R4: same index, other tag misses
    for (int i = 0; i < ENT; i++) look(mk(i * 5 + 2, i), "R4");
    // R5: alias overwrites slot 3
    upd(mk(100, 3), 12'h3A0, 1, "R5");
    look(mk(100, 3), "R5"); look(mk(16, 3), "R5");
    // R6: foreign not-taken keeps entry, own not-taken removes it
    upd(mk(55, 2), 12'h000, 0, "R6"); look(mk(11, 2), "R6");
    upd(mk(11, 2), 12'h000, 0, "R6"); look(mk(11, 2), "R6");
    // R7: redirect over a hit and over a miss
    step(mk(1, 0), 0, '0, '0, 0, 1, 12'h5C4, "R7");
    step(mk(77, 6), 0, '0, '0, 0, 1, 12'h010, "R7");
    // R8: lookup and update of slot 5 in the same cycle see old contents
    step(mk(26, 5), 1, mk(26, 5), 12'hABC, 1, 0, '0, "R8");
    look(mk(26, 5), "R8");
    step(mk(90, 4), 1, mk(90, 4), 12'h440, 1, 0, '0, "R8");
    look(mk(90, 4), "R8");
    // R9: loop branch, two runs of five iterations
    for (int r = 0; r < 2; r++) begin
      miss = 0;
      for (int k = 0; k < 5; k++) begin
        logic tk;
        tk = (k < 4);
        look(mk(40, 7), "R9");
        if (o_pt != tk || (tk && o_np != 12'h200)) miss++;
        upd(mk(40, 7), 12'h200, tk, "R9");
      end
      n_cmp++;
      if (miss != 2) begin
        n_bad++;
        $display("FAIL R9 run %0d: got %0d mispredicts, expected 2", r, miss);
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule